// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block joins two eight-line priority interrupt controllers into one sixteen-line interrupt source for a processor. The upstream controller serves lines 0 to 7 and the downstream controller serves lines 8 to 15. The downstream controller's request output feeds the upstream controller's cascade slot, which is line 2. A processor sees a single interrupt request. It fetches the interrupt number with a one-cycle acknowledge strobe. The block resolves the acknowledge on both controllers at once and returns a single 8-bit vector.

Software reaches both controllers through an 8-bit byte-wide port space. Address bit 6 picks between the controller ports and the two trigger-mode registers. For controller ports, address bit 7 picks the controller. For trigger registers, address bit 0 picks the controller. Address bits 2:0 pick the register inside a controller: 0 mask, 1 vector base, 2 control, 3 command/poll, 4 pending, 5 in-service.

Priority is fixed, and the lowest-numbered line wins. A request that is in service holds off all requests at its own level and below. When the upstream controller is in special nested mode, the cascade slot is left out of that hold-off. Each trigger-mode register can only set the bits its fixed write mask allows. Any access that is not a single byte is dropped.

Top module: `dic_cascade`

## Requirements
- R1: After reset, int_req is 0, and the mask, pending, in-service and trigger registers of both controllers read back 0.
- R2: int_req is 1 when the lowest-numbered pending, unmasked line is below the highest in-service level. Masked lines stay pending, but they do not raise int_req. An acknowledge returns {base[7:3], level}, one cycle after the strobe, and sets that level's in-service bit.
- R3: A trigger bit of 0 makes its line edge-sensitive: a rising edge latches a pending bit and an acknowledge clears it. A trigger bit of 1 makes the pending bit follow the line, and an acknowledge leaves it alone.
- R4: A write to a trigger register stores the data ANDed with 0xF8 for the upstream controller and with 0xDE for the downstream controller.
- R5: A downstream request sets upstream pending bit 2 within one cycle. If an acknowledge picks level 2, it also acknowledges the downstream controller, returns the downstream base plus the downstream level, and sets both in-service bits.
- R6: An acknowledge while int_req is 0 returns the upstream base plus 7 and changes no in-service bit.
- R7: If the upstream controller picks level 2 while the downstream controller has no active request, the vector is the downstream base plus 7.
- R8: When upstream in-service bit 2 is set, a higher downstream request raises int_req only when control bit 0 (special nested) of the upstream controller is 1.
- R9: Writing the command register with bit 3 set clears the highest-priority in-service bit. With bit 4 set, it clears the in-service bit named by bits 2:0.
- R10: A poll read of the command register returns 0x80 | level and clears that level's pending and in-service bits, or returns 0x00 when there is no request. A poll on the downstream controller also clears upstream pending and in-service bit 2.
- R11: An access with io_size other than 0 writes nothing and reads 0.
- R12: Address bit 7 selects the controller for controller ports, and bit 0 selects it for trigger registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Interrupt lines; bit 2 is taken by the cascade and has no effect |
| io_addr | input | 8 | Port address |
| io_size | input | 2 | Access size; 0 means one byte |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid the cycle after io_rd |
| int_ack | input | 1 | Acknowledge strobe, one cycle |
| int_req | output | 1 | Interrupt request to the processor |
| int_vec | output | 8 | Vector, valid the cycle after int_ack |

## Verification
Directed edges on two lines at once show whether priority order and in-service blocking work, and a masked line shows that pending bits are kept while the mask silences the request. A level line that is held and then dropped, compared with an edge line, separates the two trigger modes. A downstream line that drops before the acknowledge forces the downstream spurious vector. A nested downstream request with special nested mode off and then on shows that the cascade slot is excluded only in that mode. Random sets of upstream edges under random masks are drained by acknowledge and EOI, and the vector order is checked against a lowest-bit model, before and after the mask is lifted.

// File: rtl/dic_pkg.sv
package dic_pkg;
   localparam int LINES = 8;
   localparam int LVL_W = $clog2(LINES);
   localparam int NONE  = LINES;

   typedef enum logic [2:0] {
      REG_MASK = 3'd0,
      REG_BASE = 3'd1,
      REG_CTRL = 3'd2,
      REG_CMD  = 3'd3,
      REG_PEND = 3'd4,
      REG_SERV = 3'd5
   } reg_e;

   // lowest set index, NONE when empty
   function automatic logic [LVL_W:0] first_set(input logic [LINES-1:0] v);
      logic [LVL_W:0] r;
      r = LVL_W'(0) + (LVL_W+1)'(NONE);
      for (int i = LINES-1; i >= 0; i--)
         if (v[i]) r = (LVL_W+1)'(i);
      return r;
   endfunction
endpackage

// File: rtl/dic_decode.sv
module dic_decode #(
   parameter int ADDR_W   = 8,
   parameter int SIZE_W   = 2,
   parameter int CTL_BIT  = 7,
   parameter int TRG_BIT  = 6
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [SIZE_W-1:0] io_size,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [1:0]        ctl_wr,
   output logic [1:0]        ctl_rd,
   output logic [1:0]        trg_wr,
   output logic [1:0]        trg_rd,
   output logic [2:0]        reg_sel
);
   logic byte_ok, is_trg, side;
   logic [ADDR_W-1:0] unused_addr;

   assign unused_addr = io_addr;
   assign byte_ok = (io_size == '0);
   assign is_trg  = io_addr[TRG_BIT];
   assign side    = is_trg ? io_addr[0] : io_addr[CTL_BIT];
   assign reg_sel = io_addr[2:0];

   always_comb begin
      ctl_wr = '0; ctl_rd = '0; trg_wr = '0; trg_rd = '0;
      if (byte_ok) begin
         if (is_trg) begin
            trg_wr[side] = io_wr;
            trg_rd[side] = io_rd;
         end else begin
            ctl_wr[side] = io_wr;
            ctl_rd[side] = io_rd;
         end
      end
   end
endmodule

// File: rtl/dic_ctrl.sv
module dic_ctrl
   import dic_pkg::*;
#(
   parameter bit              UPSTREAM  = 1'b0,
   parameter logic [LINES-1:0] TRIG_MASK = '1,
   parameter int              CASC      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] lines,
   input  logic             casc_in,
   input  logic             clr_casc,
   input  logic             wr,
   input  logic             rd,
   input  logic [2:0]       reg_sel,
   input  logic [7:0]       wdata,
   input  logic             trg_wr,
   input  logic             ack,
   output logic             req,
   output logic [LVL_W-1:0] lvl,
   output logic             poll_hit,
   output logic [7:0]       rdata,
   output logic [LINES-1:0] imr_o,
   output logic [LINES-1:0] irr_o,
   output logic [LINES-1:0] isr_o,
   output logic [LINES-1:0] trig_o,
   output logic [7-LVL_W:0] base_o
);
   logic [LINES-1:0] imr_q, irr_q, isr_q, trig_q, last_q;
   logic [LINES-1:0] irr_c, isr_c, isr_eff, pend;
   logic [7-LVL_W:0] base_q;
   logic             sfn_q, poll, unused_in;
   logic [LVL_W:0]   p, c, top_srv;

   assign unused_in = casc_in ^ clr_casc ^ lines[CASC];

   assign pend = irr_q & ~imr_q;
   assign p    = first_set(pend);

   generate
      if (UPSTREAM) begin : g_up
         always_comb begin
            isr_eff = isr_q;
            if (sfn_q) isr_eff[CASC] = 1'b0;
         end
      end else begin : g_down
         assign isr_eff = isr_q;
      end
   endgenerate

   assign c        = first_set(isr_eff);
   assign top_srv  = first_set(isr_q);
   assign req      = !p[LVL_W] && (p < c);
   assign lvl      = p[LVL_W-1:0];
   assign poll     = rd && (reg_sel == REG_CMD);
   assign poll_hit = poll && req;

   always_comb begin
      for (int i = 0; i < LINES; i++) begin
         if (UPSTREAM && i == CASC)
            irr_c[i] = irr_q[i] | casc_in;
         else if (trig_q[i])
            irr_c[i] = lines[i];
         else
            irr_c[i] = irr_q[i] | (lines[i] & ~last_q[i]);
      end
      isr_c = isr_q;
      if (ack && req) begin
         isr_c[lvl] = 1'b1;
         if (!trig_q[lvl]) irr_c[lvl] = 1'b0;
      end
      if (poll_hit) begin
         irr_c[lvl] = 1'b0;
         isr_c[lvl] = 1'b0;
      end
      if (wr && reg_sel == REG_CMD) begin
         if (wdata[3] && !top_srv[LVL_W]) isr_c[top_srv[LVL_W-1:0]] = 1'b0;
         if (wdata[4]) isr_c[wdata[LVL_W-1:0]] = 1'b0;
      end
      if (UPSTREAM && clr_casc) begin
         irr_c[CASC] = 1'b0;
         isr_c[CASC] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr_q <= '0; irr_q <= '0; isr_q <= '0; trig_q <= '0;
         last_q <= '0; base_q <= '0; sfn_q <= 1'b0;
      end else begin
         irr_q  <= irr_c;
         isr_q  <= isr_c;
         last_q <= lines;
         if (trg_wr) trig_q <= wdata & TRIG_MASK;
         if (wr) begin
            case (reg_sel)
               REG_MASK: imr_q  <= wdata;
               REG_BASE: base_q <= wdata[7:LVL_W];
               REG_CTRL: sfn_q  <= wdata[0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_sel)
         REG_MASK: rdata = imr_q;
         REG_BASE: rdata = {base_q, {LVL_W{1'b0}}};
         REG_CTRL: rdata = {7'b0, sfn_q};
         REG_CMD:  rdata = req ? {1'b1, {(7-LVL_W){1'b0}}, lvl} : 8'h00;
         REG_PEND: rdata = irr_q;
         REG_SERV: rdata = isr_q;
         default:  rdata = 8'h00;
      endcase
   end

   assign imr_o  = imr_q;
   assign irr_o  = irr_q;
   assign isr_o  = isr_q;
   assign trig_o = trig_q;
   assign base_o = base_q;
endmodule

// File: rtl/dic_cascade.sv
module dic_cascade
   import dic_pkg::*;
#(
   parameter int              ADDR_W      = 8,
   parameter int              SIZE_W      = 2,
   parameter int              CTL_BIT     = 7,
   parameter int              TRG_BIT     = 6,
   parameter int              CASC_PIN    = 2,
   parameter logic [LINES-1:0] M_TRIG_MASK = 8'hF8,
   parameter logic [LINES-1:0] S_TRIG_MASK = 8'hDE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*LINES-1:0]   irq_in,
   input  logic [ADDR_W-1:0]    io_addr,
   input  logic [SIZE_W-1:0]    io_size,
   input  logic                 io_wr,
   input  logic                 io_rd,
   input  logic [7:0]           io_wdata,
   output logic [7:0]           io_rdata,
   input  logic                 int_ack,
   output logic                 int_req,
   output logic [7:0]           int_vec
);
   localparam logic [LVL_W-1:0] SPUR = LVL_W'(LINES-1);

   generate
      if (CASC_PIN >= LINES) begin : g_bad_casc
         $error("cascade pin outside controller");
      end
      if (M_TRIG_MASK[CASC_PIN] != 1'b0) begin : g_bad_mask
         $error("cascade slot must stay edge triggered");
      end
      if (CTL_BIT >= ADDR_W || TRG_BIT >= ADDR_W || CTL_BIT == TRG_BIT) begin : g_bad_addr
         $error("address select bits invalid");
      end
   endgenerate

   logic [1:0]       ctl_wr, ctl_rd, trg_wr, trg_rd;
   logic [2:0]       reg_sel;
   logic             m_req, s_req, m_poll, s_poll, s_ack;
   logic [LVL_W-1:0] m_lvl, s_lvl;
   logic [7:0]       m_rdata, s_rdata;
   logic [LINES-1:0] m_imr, m_irr, m_isr, m_trig, s_imr, s_irr, s_isr, s_trig;
   logic [7-LVL_W:0] m_base, s_base;

   dic_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CTL_BIT(CTL_BIT), .TRG_BIT(TRG_BIT)) i_dec (
      .io_addr(io_addr), .io_size(io_size), .io_wr(io_wr), .io_rd(io_rd),
      .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .trg_wr(trg_wr), .trg_rd(trg_rd), .reg_sel(reg_sel));

   assign s_ack = int_ack && m_req && (m_lvl == LVL_W'(CASC_PIN));

   dic_ctrl #(.UPSTREAM(1'b1), .TRIG_MASK(M_TRIG_MASK), .CASC(CASC_PIN)) i_up (
      .clk(clk), .rst_n(rst_n), .lines(irq_in[LINES-1:0]), .casc_in(s_req), .clr_casc(s_poll),
      .wr(ctl_wr[0]), .rd(ctl_rd[0]), .reg_sel(reg_sel), .wdata(io_wdata), .trg_wr(trg_wr[0]),
      .ack(int_ack), .req(m_req), .lvl(m_lvl), .poll_hit(m_poll), .rdata(m_rdata),
      .imr_o(m_imr), .irr_o(m_irr), .isr_o(m_isr), .trig_o(m_trig), .base_o(m_base));

   dic_ctrl #(.UPSTREAM(1'b0), .TRIG_MASK(S_TRIG_MASK), .CASC(CASC_PIN)) i_dn (
      .clk(clk), .rst_n(rst_n), .lines(irq_in[2*LINES-1:LINES]), .casc_in(1'b0), .clr_casc(1'b0),
      .wr(ctl_wr[1]), .rd(ctl_rd[1]), .reg_sel(reg_sel), .wdata(io_wdata), .trg_wr(trg_wr[1]),
      .ack(s_ack), .req(s_req), .lvl(s_lvl), .poll_hit(s_poll), .rdata(s_rdata),
      .imr_o(s_imr), .irr_o(s_irr), .isr_o(s_isr), .trig_o(s_trig), .base_o(s_base));

   logic [4*LINES+1:0] unused_view;
   assign unused_view = {s_imr, s_irr, s_isr, m_poll, m_imr[0]};

   assign int_req = m_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_vec  <= 8'h00;
         io_rdata <= 8'h00;
      end else begin
         if (int_ack) begin
            if (!m_req)
               int_vec <= {m_base, SPUR};
            else if (m_lvl == LVL_W'(CASC_PIN))
               int_vec <= {s_base, s_req ? s_lvl : SPUR};
            else
               int_vec <= {m_base, m_lvl};
         end
         if (trg_rd[0])      io_rdata <= m_trig;
         else if (trg_rd[1]) io_rdata <= s_trig;
         else if (ctl_rd[0]) io_rdata <= m_rdata;
         else if (ctl_rd[1]) io_rdata <= s_rdata;
         else if (io_rd)     io_rdata <= 8'h00;
      end
   end
endmodule

// File: rtl/dic_cascade_chk.sv
module dic_cascade_chk #(
   parameter int         CASC_PIN    = 2,
   parameter int         TRG_BIT     = 6,
   parameter logic [7:0] M_TRIG_MASK = 8'hF8
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] io_addr,
   input logic [1:0] io_size,
   input logic       io_wr,
   input logic       io_rd,
   input logic [7:0] io_wdata,
   input logic [7:0] io_rdata,
   input logic       int_ack,
   input logic       int_req,
   input logic [7:0] int_vec,
   input logic       s_req,
   input logic [7:0] m_imr,
   input logic [7:0] m_irr,
   input logic [7:0] m_isr,
   input logic [7:0] m_trig,
   input logic [4:0] m_base
);
   AST_REQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> ((m_irr & ~m_imr) != 8'h00)); // R2
   AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_req && !io_wr && !io_rd) |=> (m_isr != 8'h00)); // R2
   AST_SPURIOUS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !int_req) |=> (int_vec == {$past(m_base), 3'b111})); // R6
   AST_TRIG_WRITE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_size == 2'd0 && io_addr[TRG_BIT] && !io_addr[0]) |=>
         (m_trig == ($past(io_wdata) & M_TRIG_MASK))); // R4
   AST_CASCADE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req && !int_ack && !io_rd && !io_wr) |=> m_irr[CASC_PIN]); // R5
   AST_TOP_SERVICE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      m_isr[0] |-> !int_req); // R8
   AST_WIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_size != 2'd0) |=> (io_rdata == 8'h00)); // R11
endmodule

bind dic_cascade dic_cascade_chk #(
   .CASC_PIN(CASC_PIN), .TRG_BIT(TRG_BIT), .M_TRIG_MASK(M_TRIG_MASK)
) i_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size), .io_wr(io_wr),
   .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .int_ack(int_ack),
   .int_req(int_req), .int_vec(int_vec), .s_req(s_req), .m_imr(m_imr), .m_irr(m_irr),
   .m_isr(m_isr), .m_trig(m_trig), .m_base(m_base)
);

// File: tb/test_dic_cascade.sv
module test_dic_cascade;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_in = '0;
   logic [7:0]  io_addr = '0;
   logic [1:0]  io_size = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0, int_ack = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata, int_vec;
   logic        int_req;
   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dic_cascade i_dic_cascade (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .io_addr(io_addr), .io_size(io_size),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .int_ack(int_ack), .int_req(int_req), .int_vec(int_vec));

   localparam logic [7:0] UP = 8'h00, DN = 8'h80, TRG_UP = 8'h40, TRG_DN = 8'h41;
   localparam logic [7:0] UP_BASE = 8'h20, DN_BASE = 8'h28;

   task automatic tick(); @(posedge clk); @(negedge clk); endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [1:0] sz = 2'd0);
      io_addr = a; io_wdata = d; io_size = sz; io_wr = 1'b1;
      tick();
      io_wr = 1'b0; io_size = 2'd0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d, input logic [1:0] sz = 2'd0);
      io_addr = a; io_size = sz; io_rd = 1'b1;
      tick();
      io_rd = 1'b0; io_size = 2'd0;
      d = io_rdata;
   endtask

   task automatic ack(output logic [7:0] v);
      int_ack = 1'b1;
      tick();
      int_ack = 1'b0;
      v = int_vec;
   endtask

   function automatic logic [7:0] lowest(input logic [7:0] b);
      for (int i = 0; i < 8; i++) if (b[i]) return 8'(i);
      return 8'd8;
   endfunction

   task automatic drain(inout logic [7:0] pend, input logic [7:0] mask);
      logic [7:0] v;
      while ((pend & ~mask) != 8'h00) begin
         chk("R2 random req", {7'b0, int_req}, 8'h01);
         ack(v);
         chk("R2 random vector", v, UP_BASE + lowest(pend & ~mask));
         pend[lowest(pend & ~mask)] = 1'b0;
         wr(UP + 8'd3, 8'h08);
      end
      chk("R2 random idle", {7'b0, int_req}, 8'h00);
   endtask

   initial begin
      logic [7:0] d, v, pend, mask;
      void'($urandom(32'd1337));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 int_req", {7'b0, int_req}, 8'h00);
      rd(UP + 8'd0, d); chk("R1 up mask", d, 8'h00);
      rd(UP + 8'd4, d); chk("R1 up pending", d, 8'h00);
      rd(DN + 8'd5, d); chk("R1 dn service", d, 8'h00);
      rd(TRG_DN, d);    chk("R1 dn trigger", d, 8'h00);
      wr(UP + 8'd1, UP_BASE);
      wr(DN + 8'd1, DN_BASE);
      // R12 controller select by bit 7
      rd(UP + 8'd1, d); chk("R12 up base", d, UP_BASE);
      rd(DN + 8'd1, d); chk("R12 dn base", d, DN_BASE);
      // R4 trigger masks, R12 select by bit 0
      wr(TRG_UP, 8'hFF); wr(TRG_DN, 8'hFF);
      rd(TRG_UP, d); chk("R4 up mask", d, 8'hF8);
      rd(TRG_DN, d); chk("R4 dn mask", d, 8'hDE);
      wr(TRG_UP, 8'h00); wr(TRG_DN, 8'h00);
      rd(TRG_UP, d); chk("R12 trigger cleared", d, 8'h00);
      // R11 non-byte accesses
      wr(UP + 8'd0, 8'hFF, 2'd1);
      rd(UP + 8'd0, d); chk("R11 wide write ignored", d, 8'h00);
      rd(UP + 8'd1, d, 2'd2); chk("R11 wide read zero", d, 8'h00);
      // R6 spurious upstream
      ack(v); chk("R6 vector", v, 8'h27);
      rd(UP + 8'd5, d); chk("R6 service untouched", d, 8'h00);
      // R2 priority and in-service blocking
      irq_in[5] = 1'b1; irq_in[3] = 1'b1; tick();
      chk("R2 req", {7'b0, int_req}, 8'h01);
      ack(v); chk("R2 first vector", v, 8'h23);
      chk("R2 blocked by service", {7'b0, int_req}, 8'h00);
      wr(UP + 8'd3, 8'h08);   // R9 non-specific EOI
      chk("R9 req after EOI", {7'b0, int_req}, 8'h01);
      ack(v); chk("R2 second vector", v, 8'h25);
      wr(UP + 8'd3, 8'h08);
      rd(UP + 8'd5, d); chk("R9 service empty", d, 8'h00);
      irq_in[5] = 1'b0; irq_in[3] = 1'b0; tick();
      // R2 masking keeps pending
      wr(UP + 8'd0, 8'h10);
      irq_in[4] = 1'b1; tick();
      chk("R2 masked no req", {7'b0, int_req}, 8'h00);
      rd(UP + 8'd4, d); chk("R2 masked pending", d, 8'h10);
      wr(UP + 8'd0, 8'h00);
      chk("R2 unmask req", {7'b0, int_req}, 8'h01);
      ack(v); chk("R2 unmask vector", v, 8'h24);
      wr(UP + 8'd3, 8'h08);
      irq_in[4] = 1'b0; tick();
      // R3 level trigger
      wr(TRG_UP, 8'h08);
      irq_in[3] = 1'b1; tick();
      ack(v); chk("R3 level vector", v, 8'h23);
      rd(UP + 8'd4, d); chk("R3 level pending kept", d, 8'h08);
      wr(UP + 8'd3, 8'h13);   // R9 specific EOI level 3
      chk("R3 level re-request", {7'b0, int_req}, 8'h01);
      irq_in[3] = 1'b0; tick();
      chk("R3 level drop", {7'b0, int_req}, 8'h00);
      rd(UP + 8'd4, d); chk("R3 level pending follows", d, 8'h00);
      wr(TRG_UP, 8'h00);
      // R5 cascade
      irq_in[13] = 1'b1; tick(); tick();
      chk("R5 cascade req", {7'b0, int_req}, 8'h01);
      ack(v); chk("R5 cascade vector", v, 8'h2D);
      rd(UP + 8'd5, d); chk("R5 up service", d, 8'h04);
      rd(DN + 8'd5, d); chk("R5 dn service", d, 8'h20);
      // R8 nesting through the cascade slot
      irq_in[9] = 1'b1; tick(); tick();
      chk("R8 no nesting without mode", {7'b0, int_req}, 8'h00);
      wr(UP + 8'd2, 8'h01);
      chk("R8 nesting with mode", {7'b0, int_req}, 8'h01);
      ack(v); chk("R8 nested vector", v, 8'h29);
      rd(DN + 8'd5, d); chk("R8 dn service", d, 8'h22);
      wr(DN + 8'd3, 8'h08);
      rd(DN + 8'd5, d); chk("R9 highest cleared first", d, 8'h20);
      wr(DN + 8'd3, 8'h08); wr(UP + 8'd3, 8'h08); wr(UP + 8'd2, 8'h00);
      irq_in[13] = 1'b0; irq_in[9] = 1'b0; tick();
      chk("R8 idle", {7'b0, int_req}, 8'h00);
      // R7 downstream spurious
      wr(TRG_DN, 8'h08);
      irq_in[11] = 1'b1; tick(); tick();
      irq_in[11] = 1'b0; tick();
      chk("R7 req held by slot", {7'b0, int_req}, 8'h01);
      ack(v); chk("R7 vector", v, 8'h2F);
      rd(DN + 8'd5, d); chk("R7 dn service", d, 8'h00);
      wr(UP + 8'd3, 8'h08); wr(TRG_DN, 8'h00);
      // R10 poll
      irq_in[6] = 1'b1; tick();
      rd(UP + 8'd3, d); chk("R10 poll value", d, 8'h86);
      rd(UP + 8'd4, d); chk("R10 poll cleared", d, 8'h00);
      chk("R10 poll quiet", {7'b0, int_req}, 8'h00);
      rd(UP + 8'd3, d); chk("R10 poll empty", d, 8'h00);
      irq_in[6] = 1'b0;
      irq_in[12] = 1'b1; tick(); tick();
      rd(DN + 8'd3, d); chk("R10 dn poll value", d, 8'h84);
      rd(UP + 8'd4, d); chk("R10 up slot cleared", d, 8'h00);
      chk("R10 dn poll quiet", {7'b0, int_req}, 8'h00);
      irq_in[12] = 1'b0; tick();
      // R9 specific EOI order
      irq_in[1] = 1'b1; irq_in[6] = 1'b1; tick();
      ack(v); chk("R9 first", v, 8'h21);
      wr(UP + 8'd3, 8'h11);
      ack(v); chk("R9 second", v, 8'h26);
      rd(UP + 8'd5, d); chk("R9 service 6", d, 8'h40);
      wr(UP + 8'd3, 8'h16);
      rd(UP + 8'd5, d); chk("R9 specific cleared", d, 8'h00);
      irq_in[1] = 1'b0; irq_in[6] = 1'b0; tick();
      // random edges under random masks (R2, R3)
      for (int n = 0; n < 24; n++) begin
         pend = 8'($urandom) & 8'hFB;
         mask = 8'($urandom) & 8'hFB;
         wr(UP + 8'd0, mask);
         irq_in[7:0] = pend; tick();
         irq_in[7:0] = 8'h00; tick();
         drain(pend, mask);
         rd(UP + 8'd4, d); chk("R2 masked remain", d, pend);
         wr(UP + 8'd0, 8'h00);
         drain(pend, 8'h00);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule